// File: doc/BRIEF.md
# Run-Mode Clock Enable Generator

This block derives per-domain clock-enable pulses from a single fast reference clock for three functional domains of differing criticality: a high domain, a medium domain and a low domain. A two-bit run-mode select picks between a normal mode, a low-power mode and an ultra-low-power mode. Each mode assigns every domain a divide ratio of the fast clock. A domain with ratio N has its enable asserted on one fast edge in every N. Data launched from a faster domain into a slower one therefore has N fast cycles to arrive.

Three more enables pace transfers between each pair of domains. Each of these runs at the rate of the slower domain of its pair. In ultra-low-power mode the low domain's ratio k is programmable. The block counts fast cycles in frames. A frame is the least common multiple of the active medium and low ratios. The mode and k are sampled only on the first cycle of a frame, so a reconfiguration never shortens an enable period. Downstream logic uses the enables to qualify register updates or to drive gating cells.

Top module: `rmce_top`

## Requirements
- R1: While reset is held, all six enables are low. The frame counters restart from zero, and every enable is high in the first cycle after reset is released.
- R2: The high-domain enable is high in every cycle after reset, in all modes.
- R3: Mode code 2'b00 (normal), and the spare code 2'b11 treated the same way: the medium enable fires every cycle and the low enable fires every second cycle.
- R4: Mode code 2'b01 (low power): the medium and low enables both fire every second cycle, on the same cycles.
- R5: Mode code 2'b10 (ultra low power): the medium enable fires every second cycle and the low enable fires once every k cycles, where k is the divisor input.
- R6: A divisor value below 3 is used as 3, and a value above 8 is used as 8.
- R7: Each pair enable (high/medium, high/low, medium/low) equals the enable of whichever domain of the pair has the larger ratio.
- R8: A frame lasts the least common multiple of the active medium and low ratios. Mode and divisor are taken from the inputs only in frame position 0 and are held for the rest of the frame. Every divided enable fires at position 0.
- R9: Within a frame, a domain of ratio N fires exactly at the positions that are multiples of N. An enable with a ratio of 2 or more is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Run-mode select: 00 normal, 01 low power, 10 ultra low power, 11 as normal |
| kdiv_i | input | 4 | Low-domain divisor for ultra-low-power mode, clamped to 3..8 |
| en_hi_o | output | 1 | High-domain enable pulse |
| en_med_o | output | 1 | Medium-domain enable pulse |
| en_lo_o | output | 1 | Low-domain enable pulse |
| xfer_hm_o | output | 1 | High/medium transfer enable |
| xfer_hl_o | output | 1 | High/low transfer enable |
| xfer_ml_o | output | 1 | Medium/low transfer enable |

## Verification
The hardest case to reach is a mode or divisor change that lands in the middle of a long frame. An odd k in ultra-low-power mode gives a frame of 2k, up to 14 cycles. A late change must be ignored until the frame wraps, and only then change the pattern. The bench first sweeps every mode code against every divisor value for several frames each. It then changes mode and divisor on every cycle from a pseudo-random sequence, so that changes fall on every frame position, including the last one before a wrap and position 0 itself.

// File: rtl/rmce_pkg.sv
package rmce_pkg;

   typedef enum logic [1:0] {
      RM_NORMAL = 2'b00,
      RM_LOWPWR = 2'b01,
      RM_ULTRA  = 2'b10,
      RM_SPARE  = 2'b11
   } run_mode_e;

   localparam int DOM_N  = 3;
   localparam int PAIR_N = 3;

   // pair index -> domain indices: 0:(hi,med) 1:(hi,lo) 2:(med,lo)
   function automatic int pair_a(input int p);
      return (p == 2) ? 1 : 0;
   endfunction

   function automatic int pair_b(input int p);
      return (p == 0) ? 1 : 2;
   endfunction

endpackage

// File: rtl/rmce_cfg_decode.sv
module rmce_cfg_decode
   import rmce_pkg::*;
#(
   parameter int DIV_W = 4,
   parameter int K_MIN = 3,
   parameter int K_MAX = 8,
   parameter int RAT_W = 4,
   parameter int FRM_W = 5
) (
   input  logic [1:0]       mode_i,
   input  logic [DIV_W-1:0] kdiv_i,
   output logic [RAT_W-1:0] rat_med_o,
   output logic [RAT_W-1:0] rat_lo_o,
   output logic [FRM_W-1:0] frame_len_o
);

   localparam logic [DIV_W-1:0] KMIN_D = DIV_W'(K_MIN);
   localparam logic [DIV_W-1:0] KMAX_D = DIV_W'(K_MAX);

   logic [RAT_W-1:0] k_cl;
   run_mode_e        mode;

   assign mode = run_mode_e'(mode_i);

   always_comb begin
      if (kdiv_i < KMIN_D) begin
         k_cl = RAT_W'(K_MIN);
      end else if (kdiv_i > KMAX_D) begin
         k_cl = RAT_W'(K_MAX);
      end else begin
         k_cl = RAT_W'(kdiv_i);
      end
   end

   always_comb begin
      unique case (mode)
         RM_LOWPWR: begin
            rat_med_o = RAT_W'(2);
            rat_lo_o  = RAT_W'(2);
         end
         RM_ULTRA: begin
            rat_med_o = RAT_W'(2);
            rat_lo_o  = k_cl;
         end
         default: begin
            rat_med_o = RAT_W'(1);
            rat_lo_o  = RAT_W'(2);
         end
      endcase
   end

   // medium ratio is 1 or 2, low ratio >= 2: lcm is lo, or 2*lo if lo odd and med 2
   always_comb begin
      if (rat_med_o == RAT_W'(2) && rat_lo_o[0]) begin
         frame_len_o = FRM_W'({rat_lo_o, 1'b0});
      end else begin
         frame_len_o = FRM_W'(rat_lo_o);
      end
   end

endmodule

// File: rtl/rmce_frame_ctr.sv
module rmce_frame_ctr #(
   parameter int RAT_W = 4,
   parameter int FRM_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [RAT_W-1:0] live_med_i,
   input  logic [RAT_W-1:0] live_lo_i,
   input  logic [FRM_W-1:0] live_frame_i,
   output logic [RAT_W-1:0] act_med_o,
   output logic [RAT_W-1:0] act_lo_o,
   output logic             frame_last_o
);

   logic [FRM_W-1:0] pos_q;
   logic [RAT_W-1:0] held_med_q;
   logic [RAT_W-1:0] held_lo_q;
   logic [FRM_W-1:0] held_frame_q;
   logic [FRM_W-1:0] act_frame;
   logic             at_start;

   assign at_start     = (pos_q == '0);
   assign act_med_o    = at_start ? live_med_i   : held_med_q;
   assign act_lo_o     = at_start ? live_lo_i    : held_lo_q;
   assign act_frame    = at_start ? live_frame_i : held_frame_q;
   assign frame_last_o = (pos_q == act_frame - FRM_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q        <= '0;
         held_med_q   <= RAT_W'(1);
         held_lo_q    <= RAT_W'(2);
         held_frame_q <= FRM_W'(2);
      end else begin
         pos_q <= frame_last_o ? '0 : pos_q + FRM_W'(1);
         if (at_start) begin
            held_med_q   <= live_med_i;
            held_lo_q    <= live_lo_i;
            held_frame_q <= live_frame_i;
         end
      end
   end

   AST_POS_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pos_q < act_frame); // R8
   AST_CFG_HELD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pos_q != '0) |-> (act_lo_o == $past(act_lo_o) && act_med_o == $past(act_med_o))); // R8

endmodule

// File: rtl/rmce_div_tap.sv
module rmce_div_tap #(
   parameter int RAT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [RAT_W-1:0] ratio_i,
   input  logic             restart_i,
   output logic             fire_o
);

   logic [RAT_W-1:0] sub_q;

   assign fire_o = (sub_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sub_q <= '0;
      end else if (restart_i || sub_q >= ratio_i - RAT_W'(1)) begin
         sub_q <= '0;
      end else begin
         sub_q <= sub_q + RAT_W'(1);
      end
   end

   AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o && ratio_i > RAT_W'(1)) |=> !fire_o); // R9
   AST_FIRE_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> fire_o); // R8

endmodule

// File: rtl/rmce_top.sv
module rmce_top
   import rmce_pkg::*;
#(
   parameter int DIV_W = 4,
   parameter int K_MIN = 3,
   parameter int K_MAX = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       mode_i,
   input  logic [DIV_W-1:0] kdiv_i,
   output logic             en_hi_o,
   output logic             en_med_o,
   output logic             en_lo_o,
   output logic             xfer_hm_o,
   output logic             xfer_hl_o,
   output logic             xfer_ml_o
);

   localparam int RAT_W = $clog2(K_MAX + 1);
   localparam int FRM_W = $clog2(2 * K_MAX + 1);

   if (K_MIN < 2 || K_MIN > K_MAX) begin : g_bad_krange
      $error("rmce_top: divisor range must satisfy 2 <= K_MIN <= K_MAX");
   end
   if (K_MAX >= (1 << DIV_W)) begin : g_bad_divw
      $error("rmce_top: DIV_W too narrow for K_MAX");
   end

   logic [RAT_W-1:0] live_med, live_lo;
   logic [FRM_W-1:0] live_frame;
   logic [RAT_W-1:0] act_med, act_lo;
   logic             frame_last;
   logic [RAT_W-1:0] rat   [DOM_N];
   logic [DOM_N-1:0] en;
   logic [PAIR_N-1:0] xfer;

   rmce_cfg_decode #(
      .DIV_W(DIV_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .RAT_W(RAT_W), .FRM_W(FRM_W)
   ) u_dec (
      .mode_i      (mode_i),
      .kdiv_i      (kdiv_i),
      .rat_med_o   (live_med),
      .rat_lo_o    (live_lo),
      .frame_len_o (live_frame)
   );

   rmce_frame_ctr #(.RAT_W(RAT_W), .FRM_W(FRM_W)) u_frm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .live_med_i   (live_med),
      .live_lo_i    (live_lo),
      .live_frame_i (live_frame),
      .act_med_o    (act_med),
      .act_lo_o     (act_lo),
      .frame_last_o (frame_last)
   );

   assign rat[0] = RAT_W'(1);
   assign rat[1] = act_med;
   assign rat[2] = act_lo;

   for (genvar d = 0; d < DOM_N; d++) begin : g_dom
      if (d == 0) begin : g_full
         assign en[d] = rst_ni;
      end else begin : g_div
         logic fire;
         rmce_div_tap #(.RAT_W(RAT_W)) u_tap (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ratio_i   (rat[d]),
            .restart_i (frame_last),
            .fire_o    (fire)
         );
         assign en[d] = fire & rst_ni;
      end
   end

   for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
      localparam int A = pair_a(p);
      localparam int B = pair_b(p);
      assign xfer[p] = (rat[A] >= rat[B]) ? en[A] : en[B];
   end

   assign en_hi_o   = en[0];
   assign en_med_o  = en[1];
   assign en_lo_o   = en[2];
   assign xfer_hm_o = xfer[0];
   assign xfer_hl_o = xfer[1];
   assign xfer_ml_o = xfer[2];

   AST_HI_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_hi_o); // R2
   AST_EQUAL_RATIO_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_med == act_lo) |-> (en_med_o == en_lo_o)); // R4
   AST_LO_RATIO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_lo >= RAT_W'(2) && act_lo <= RAT_W'(K_MAX)); // R6
   AST_XFER_ML_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_ml_o |-> en_lo_o); // R7
   AST_XFER_HM_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_hm_o |-> (en_med_o && en_hi_o)); // R7

endmodule

// File: tb/rmce_top_tb_top.sv
module rmce_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [3:0] kdiv = 4'd0;
   logic en_hi, en_med, en_lo, x_hm, x_hl, x_ml;

   int n_cmp = 0;
   int n_bad = 0;

   int pos = 0;
   int am = 1, al = 2, af = 2;
   logic [31:0] lfsr = 32'h1ACE_5EED;

   always #5 clk = ~clk;

   rmce_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .kdiv_i(kdiv),
      .en_hi_o(en_hi), .en_med_o(en_med), .en_lo_o(en_lo),
      .xfer_hm_o(x_hm), .xfer_hl_o(x_hl), .xfer_ml_o(x_ml)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b (mode %0d k %0d pos %0d)",
                  tag, what, act, exp, mode, kdiv, pos);
      end
   endtask

   // expected ratios from the requirements
   task automatic decode(input int m, input int k, output int rm, output int rl, output int fr);
      int kc;
      kc = (k < 3) ? 3 : ((k > 8) ? 8 : k);
      if (m == 1) begin rm = 2; rl = 2; end
      else if (m == 2) begin rm = 2; rl = kc; end
      else begin rm = 1; rl = 2; end
      fr = (rl % rm == 0) ? rl : rl * rm;
   endtask

   // compare one cycle at the falling edge, then advance the model
   task automatic check_cycle(input bit rand_phase);
      logic e_med, e_lo;
      string tm, tl, tx;
      @(negedge clk);
      if (pos == 0) decode(int'(mode), int'(kdiv), am, al, af);
      e_med = (pos % am) == 0;
      e_lo  = (pos % al) == 0;
      if (rand_phase) begin
         tm = "R8"; tl = "R8"; tx = "R8";
      end else begin
         tm = (mode == 2'd1) ? "R4" : ((mode == 2'd2) ? "R5" : "R3");
         tl = (mode == 2'd2 && (kdiv < 4'd3 || kdiv > 4'd8)) ? "R6" : "R9";
         tx = "R7";
      end
      chk("R2", "en_hi", en_hi, 1'b1);
      chk(tm, "en_med", en_med, e_med);
      chk(tl, "en_lo", en_lo, e_lo);
      chk(tx, "xfer_hm", x_hm, (am >= 1) ? e_med : 1'b1);
      chk(tx, "xfer_hl", x_hl, e_lo);
      chk(tx, "xfer_ml", x_ml, (al >= am) ? e_lo : e_med);
      pos = (pos == af - 1) ? 0 : pos + 1;
   endtask

   task automatic set_inputs(input logic [1:0] m, input logic [3:0] k);
      @(posedge clk);
      #1;
      mode = m;
      kdiv = k;
   endtask

   initial begin
      // R1: outputs low during reset
      mode = 2'd2; kdiv = 4'd5;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "en_hi in reset", en_hi, 1'b0);
      chk("R1", "en_med in reset", en_med, 1'b0);
      chk("R1", "en_lo in reset", en_lo, 1'b0);
      chk("R1", "xfer_ml in reset", x_ml, 1'b0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      pos = 0;
      // R1: first cycle after release, everything fires
      @(negedge clk);
      chk("R1", "first en_hi", en_hi, 1'b1);
      chk("R1", "first en_med", en_med, 1'b1);
      chk("R1", "first en_lo", en_lo, 1'b1);
      chk("R1", "first xfer_hl", x_hl, 1'b1);
      decode(2, 5, am, al, af);
      pos = 1;
      for (int c = 0; c < 30; c++) begin
         @(posedge clk);
         check_cycle(1'b0);
      end
      // exhaustive sweep of mode code x divisor value
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 16; k++) begin
            set_inputs(2'(m), 4'(k));
            check_cycle(1'b0);
            for (int c = 0; c < 40; c++) begin
               @(posedge clk);
               check_cycle(1'b0);
            end
         end
      end
      // R8: changes on every cycle, landing on every frame position
      for (int c = 0; c < 3000; c++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         set_inputs(lfsr[5:4], lfsr[3:0]);
         check_cycle(1'b1);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule